// File: doc/BRIEF.md
# Sum-of-Products Logic Block

This block is one logic tile of a small programmable device. Eighteen routed input signals enter a programmable AND plane. Each product term can use the true form, the inverted form or neither form of each input. Any product term can be gathered into any of four OR sums. Each sum then passes a polarity XOR and reaches a macrocell. The macrocell either passes the value straight through or stores it in a flip-flop. The four macrocell outputs form the block's feedback bus, which routing outside the block can send to any tile.

All behaviour comes from static configuration inputs. The register clock is chosen once for the whole block. It is either one of three global clocks or a private clock taken from the block's last product term. An active-low asynchronous reset clears all four flip-flops.

Top module: `sop_logic_block`

## Requirements
- R1: Product term p takes its connection bits from `and_cfg[p*36 +: 36]`. Bit 2i connects input i in true form and bit 2i+1 connects it in inverted form. The term is the AND of all connected literals.
- R2: A product term with no connection bits set evaluates to 0.
- R3: Bit `or_cfg[m*20 + p]` adds product term p to the OR sum of macrocell m. A term may feed several macrocells at once.
- R4: When `inv_cfg[m]` is 1, the sum of macrocell m is inverted before the macrocell. When it is 0, the sum passes unchanged.
- R5: When `bypass_cfg[m]` is 1, `dout[m]` follows the polarity-corrected sum combinationally, in the same cycle the inputs change.
- R6: When `bypass_cfg[m]` is 0, `dout[m]` shows a flip-flop. The flip-flop loads the polarity-corrected sum only on a rising edge of the selected clock and holds its value at all other times.
- R7: `clk_sel` values 0, 1 and 2 pick `gclk[0]`, `gclk[1]` and `gclk[2]`. Value 3 picks product term 19. The clocks that are not selected do not load the flip-flops.
- R8: While `rst_n` is low, all four flip-flops read 0 at once, with no clock edge needed. Outputs in bypass mode keep following their sums.
- R9: A product term that connects both the true and the inverted form of the same input evaluates to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| gclk | input | 3 | Global clocks, one of which may drive the flip-flops |
| rst_n | input | 1 | Asynchronous active-low flip-flop clear |
| din | input | 18 | Routed input signals |
| and_cfg | input | 720 | AND-plane connections, 36 bits per product term |
| or_cfg | input | 80 | Term-to-sum selection, 20 bits per macrocell |
| inv_cfg | input | 4 | Polarity inversion per macrocell |
| bypass_cfg | input | 4 | 1 = combinational output, 0 = registered output |
| clk_sel | input | 2 | Register clock choice: 0-2 global clocks, 3 product term 19 |
| dout | output | 4 | Macrocell outputs, also the feedback bus |

## Verification
A bypassed output depends only on logic, so it is due in the same cycle its inputs or configuration change. The bench samples it 1 ns after each drive. A registered output changes only at the rising edge of the selected clock. The bench raises that clock on a falling edge of the bench clock, computes the expected capture from the inputs held at that moment, and compares 1 ns later. Before each clock pulse it also checks that new inputs and pulses on the unselected clocks leave the output unchanged. For the product-term clock, the bench keeps input 17 out of every sum term. Raising input 17 then causes the capture without changing the data being captured.

// File: rtl/sop_logic_block.sv
module sop_logic_block #(
  parameter int N_IN   = 18,
  parameter int N_TERM = 20,
  parameter int N_CELL = 4
) (
  input  logic [2:0]               gclk,
  input  logic                     rst_n,
  input  logic [N_IN-1:0]          din,
  input  logic [N_TERM*2*N_IN-1:0] and_cfg,
  input  logic [N_CELL*N_TERM-1:0] or_cfg,
  input  logic [N_CELL-1:0]        inv_cfg,
  input  logic [N_CELL-1:0]        bypass_cfg,
  input  logic [1:0]               clk_sel,
  output logic [N_CELL-1:0]        dout
);
  localparam int LW = 2 * N_IN;
  localparam int CLK_TERM = N_TERM - 1;
  localparam logic [LW-1:0] TRUE_MASK = {N_IN{2'b01}};

  logic [LW-1:0]     lit;
  logic [N_TERM-1:0] term, used, clash;
  logic [N_CELL-1:0] d, q;
  logic              reg_clk, armed;

  generate
    for (genvar i = 0; i < N_IN; i++) begin : g_lit
      assign lit[2*i]   = din[i];
      assign lit[2*i+1] = ~din[i];
    end

    for (genvar p = 0; p < N_TERM; p++) begin : g_term
      logic [LW-1:0] conn;
      assign conn     = and_cfg[p*LW +: LW];
      assign used[p]  = |conn;
      assign clash[p] = |(conn & (conn >> 1) & TRUE_MASK);
      assign term[p]  = used[p] & (&(lit | ~conn));
    end
  endgenerate

  always_comb begin
    case (clk_sel)
      2'd0:    reg_clk = gclk[0];
      2'd1:    reg_clk = gclk[1];
      2'd2:    reg_clk = gclk[2];
      default: reg_clk = term[CLK_TERM];
    endcase
  end

  always_ff @(posedge reg_clk or negedge rst_n) begin
    if (!rst_n) begin
      q     <= '0;
      armed <= 1'b0;
    end else begin
      q     <= d;
      armed <= 1'b1;
    end
  end

  generate
    for (genvar m = 0; m < N_CELL; m++) begin : g_cell
      logic [N_TERM-1:0] pick;
      assign pick    = or_cfg[m*N_TERM +: N_TERM];
      assign d[m]    = (|(term & pick)) ^ inv_cfg[m];
      assign dout[m] = bypass_cfg[m] ? d[m] : q[m];

      // R2 and R9: a cell fed only by empty or self-contradicting terms shows its polarity bit
      always_comb begin
        if (rst_n && bypass_cfg[m] && ((pick & used & ~clash) == '0))
          p_dead_terms_r2: assert (dout[m] == inv_cfg[m]);
      end

      always_comb begin
        if (bypass_cfg[m] && (|(term & pick)))
          p_polarity_r4: assert (dout[m] == ~inv_cfg[m]);
      end
    end
  endgenerate

  p_capture_r6: assert property (@(posedge reg_clk) disable iff (!rst_n)
    armed |=> (q == $past(d)));

  p_reset_clear_r8: assert property (@(posedge gclk[0]) disable iff (!rst_n)
    ($rose(rst_n) && clk_sel == 2'd0) |-> ((dout & ~bypass_cfg) == '0));
endmodule

// File: tb/sop_logic_block_bench.sv
module sop_logic_block_bench;
  logic         clk = 1'b0;
  logic [2:0]   gclk = 3'b000;
  logic         rst_n = 1'b0;
  logic [17:0]  din = '0;
  logic [719:0] and_cfg = '0;
  logic [79:0]  or_cfg = '0;
  logic [3:0]   inv_cfg = '0;
  logic [3:0]   bypass_cfg = '0;
  logic [1:0]   clk_sel = 2'd0;
  logic [3:0]   dout;
  logic [3:0]   mq = '0;
  int unsigned  total = 0, fails = 0, seed_tmp;

  always #2 clk = ~clk;

  sop_logic_block u_sop_logic_block (
    .gclk(gclk), .rst_n(rst_n), .din(din), .and_cfg(and_cfg), .or_cfg(or_cfg),
    .inv_cfg(inv_cfg), .bypass_cfg(bypass_cfg), .clk_sel(clk_sel), .dout(dout)
  );

  function automatic logic [3:0] ref_d(input logic [17:0] x);
    logic [19:0] t;
    logic [3:0]  r;
    for (int p = 0; p < 20; p++) begin
      logic [35:0] c;
      c = and_cfg[p*36 +: 36];
      t[p] = (c != 0);
      for (int i = 0; i < 18; i++) begin
        if (c[2*i] && !x[i]) t[p] = 1'b0;
        if (c[2*i+1] && x[i]) t[p] = 1'b0;
      end
    end
    for (int m = 0; m < 4; m++) r[m] = ((t & or_cfg[m*20 +: 20]) != 0) ^ inv_cfg[m];
    return r;
  endfunction

  function automatic logic [3:0] exp_out();
    return (bypass_cfg & ref_d(din)) | (~bypass_cfg & mq);
  endfunction

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic rand_cfg();
    for (int b = 0; b < 720; b++) and_cfg[b] = ($urandom % 12) == 0;
    or_cfg  = {$urandom, $urandom, $urandom};
    inv_cfg = 4'($urandom);
  endtask

  task automatic pulse(input int k);
    @(negedge clk);
    gclk[k] = 1'b1;
    if (k == int'(clk_sel)) mq = ref_d(din);
    #1 check(k == int'(clk_sel) ? "R7 selected clock loads" : "R7 other clock ignored", dout, exp_out());
    @(negedge clk);
    gclk[k] = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    seed_tmp = $urandom(32'h5eed);
    // R8 reset state with registered outputs
    @(negedge clk); #1 check("R8 reset clears", dout, 4'b0000);
    @(negedge clk); rst_n = 1'b1;

    // Directed: term0 = in0 & ~in1, term1 = in2, term2 = in3 & ~in3, term5 empty
    and_cfg = '0;
    and_cfg[0*36 + 0] = 1'b1; and_cfg[0*36 + 3] = 1'b1;
    and_cfg[1*36 + 4] = 1'b1;
    and_cfg[2*36 + 6] = 1'b1; and_cfg[2*36 + 7] = 1'b1;
    or_cfg = '0;
    or_cfg[0*20 + 0] = 1'b1;
    or_cfg[1*20 + 5] = 1'b1;
    or_cfg[2*20 + 2] = 1'b1;
    or_cfg[3*20 + 0] = 1'b1; or_cfg[3*20 + 1] = 1'b1;
    inv_cfg = 4'b0000; bypass_cfg = 4'b1111;
    din = 18'h0; #1 check("R1 R2 all low", dout, 4'b0000);
    @(negedge clk); din = 18'h1; #1 check("R1 R3 literal match", dout, 4'b1001);
    @(negedge clk); din = 18'h3; #1 check("R1 inverted literal blocks", dout, 4'b0000);
    @(negedge clk); din = 18'h4; #1 check("R3 second term into sum", dout, 4'b1000);
    @(negedge clk); din = 18'h9; #1 check("R9 contradiction stays low", dout, 4'b1001);
    @(negedge clk); inv_cfg = 4'b0110; din = 18'h0; #1 check("R4 R2 inverted empty", dout, 4'b0110);
    @(negedge clk); din = 18'h1; #1 check("R4 R5 inverted mix", dout, 4'b1111);

    // Random combinational path
    for (int n = 0; n < 40; n++) begin
      @(negedge clk);
      rand_cfg();
      bypass_cfg = 4'b1111;
      din = 18'($urandom);
      #1 check("R5 random combinational", dout, ref_d(din));
    end

    // Registered path under each global clock
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      clk_sel = 2'(k);
      rand_cfg();
      bypass_cfg = 4'b0000;
      #1 check("R6 hold after config change", dout, mq);
      for (int n = 0; n < 12; n++) begin
        @(negedge clk);
        din = 18'($urandom);
        if (n % 2 == 1) bypass_cfg = 4'($urandom);
        #1 check("R6 hold on input change", dout, exp_out());
        pulse((k + 1) % 3);
        pulse(k);
      end
    end

    // Product-term clock: term 19 = in17, no other term uses in17
    @(negedge clk);
    rand_cfg();
    for (int p = 0; p < 20; p++) begin
      and_cfg[p*36 + 34] = 1'b0;
      and_cfg[p*36 + 35] = 1'b0;
    end
    and_cfg[19*36 +: 36] = '0;
    and_cfg[19*36 + 34] = 1'b1;
    for (int m = 0; m < 4; m++) or_cfg[m*20 + 19] = 1'b0;
    din[17] = 1'b0;
    bypass_cfg = 4'b0000;
    @(negedge clk); clk_sel = 2'd3;
    #1 check("R7 switch to term clock holds", dout, mq);
    for (int n = 0; n < 12; n++) begin
      @(negedge clk);
      din = {1'b0, 17'($urandom)};
      #1 check("R6 hold under term clock", dout, mq);
      pulse(n % 3);
      @(negedge clk);
      din[17] = 1'b1;
      mq = ref_d(din);
      #1 check("R7 term clock loads", dout, mq);
      @(negedge clk);
      din[17] = 1'b0;
      #1 check("R7 falling term clock holds", dout, mq);
    end

    // Asynchronous reset mid-run
    @(negedge clk);
    bypass_cfg = 4'b0101;
    din = {1'b0, 17'($urandom)};
    rst_n = 1'b0;
    mq = 4'b0000;
    #1 check("R8 async clear with bypass mix", dout, exp_out());
    @(negedge clk);
    bypass_cfg = 4'b0000;
    #1 check("R8 async clear registered", dout, 4'b0000);
    @(negedge clk); rst_n = 1'b1;
    #1 check("R8 stays clear after release", dout, 4'b0000);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule